// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid, dirty and replacement bookkeeping of a write-back, set-associative cache. It receives one access per cycle, each an address plus a read/write flag. For each access it returns a status record one cycle later. The record gives the set index, the tag, hit or miss, the way that now holds the block, and the dirty state of that line after the access. It also carries two separate flags: one says whether a resident block had to be displaced, and the other says whether that displaced block must be written back to the next memory level. Data storage and the transfer to the next level sit outside this block, which only raises the flags.

The geometry comes from parameters: address width, cache size, block size, addressable unit and ways per set. All of them must be powers of two, and the cache must have at least two sets. A one-way configuration gives a direct-mapped cache. The `policy_lru` input selects the victim policy. When it is high, the least recently used line is the victim. When it is low, the line filled earliest is the victim.

After reset the controller is in state `ST_INIT`. In that state it walks a counter across the sets, one set per cycle. For each set it clears the valid and dirty bits and loads the replacement order so that way 0 is the oldest. The transitions are:
- `ST_INIT` goes back to `ST_INIT` while the counter has not reached the last set.
- `ST_INIT` goes to `ST_SERVE` on the cycle that clears the last set.
- `ST_SERVE` stays in `ST_SERVE`.
- Reset sends either state to `ST_INIT`.

`req_ready` is high only in `ST_SERVE`.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits into three fields. The lowest log2(BLOCK_BYTES/UNIT_BYTES) bits are the block offset and are ignored. The next log2(sets) bits are the set index, reported on `rsp_index`. All remaining upper bits are the tag, reported on `rsp_tag`.
- R2: After synchronous reset is released, `req_ready` stays low for exactly as many cycles as there are sets. `rsp_valid` is low during reset. When the sweep ends, every line is invalid.
- R3: An access is accepted in a cycle where `req_valid` and `req_ready` are both high. Its record appears with `rsp_valid` high exactly one cycle later. Back-to-back accesses give one record per cycle. `rsp_valid` is low in any cycle that follows a cycle with no accepted access.
- R4: An access hits when a valid way of the indexed set holds its tag. `rsp_hit` is then 1 and `rsp_way` gives that way.
- R5: On a miss while the set still has an invalid way, the block fills the lowest-numbered invalid way. `rsp_replace` is 0 in that case.
- R6: With `policy_lru` high and the set full, a miss evicts the way whose most recent access (hit or fill) is oldest.
- R7: With `policy_lru` low and the set full, a miss evicts the way filled earliest. Hits do not change this order.
- R8: After a write, the line's dirty bit is 1, whether the write hit or filled the line after a miss. A read miss fills a clean line. A read hit keeps the line's dirty bit. `rsp_dirty` reports the line's dirty bit after the access.
- R9: `rsp_replace` is 1 only on a miss that removes a valid block, which happens only when every way of the set is valid.
- R10: `rsp_writeback` is 1 only when the block removed by the access was dirty.
- R11: With one way per set, every miss to a set that holds a valid block replaces that block. The record shows way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| policy_lru | input | 1 | 1 selects least-recently-used victims, 0 selects first-filled victims |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept an access this cycle |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Status record valid |
| rsp_index | output | IDX_W | Set index of the access |
| rsp_tag | output | TAG_W | Tag of the access |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_way | output | WAY_W | Way that holds the block after the access |
| rsp_dirty | output | 1 | Dirty bit of that line after the access |
| rsp_replace | output | 1 | A valid block was displaced |
| rsp_writeback | output | 1 | The displaced block was dirty and needs writing back |

## Verification
The bench fills one set completely and then touches the lines in chosen orders. A mix-up between the two victim orders, or a hit that fails to refresh its line under LRU, then shows up as a wrong `rsp_way` on the next eviction. Write hits before an eviction check the write-back flag: a controller that dropped the dirty bit on a hit, or that kept dirty state across a refill, would raise the flag wrongly or miss it. The bench also runs a direct-mapped copy in parallel, where every conflicting miss must report a replacement. It counts the init sweep length of both copies, which catches an off-by-one in the sweep that would either accept accesses into uncleared sets or stall for a cycle too long.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [0:0] {
        ST_INIT  = 1'b0,
        ST_SERVE = 1'b1
    } ctl_state_e;

    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/ctc_way_match.sv
module ctc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    parameter int WAY_W = 2
) (
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]       valid_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  hit_o,
    output logic [WAY_W-1:0]      hit_way_o,
    output logic                  free_o,
    output logic [WAY_W-1:0]      free_way_o
);

    logic [WAYS-1:0] eq_vec;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign eq_vec[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
        end
    endgenerate

    // Walk from the top so the lowest-numbered candidate wins.
    always_comb begin
        hit_way_o  = '0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq_vec[w])   hit_way_o  = WAY_W'(w);
            if (!valid_i[w]) free_way_o = WAY_W'(w);
        end
    end

    assign hit_o  = |eq_vec;
    assign free_o = ~&valid_i;

endmodule

// File: rtl/ctc_victim_pick.sv
module ctc_victim_pick #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 2
) (
    input  logic [WAYS*RANK_W-1:0] ranks_i,
    output logic [RANK_W-1:0]      victim_o
);

    // Rank WAYS-1 marks the oldest line in the set.
    always_comb begin
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ranks_i[w*RANK_W +: RANK_W] == RANK_W'(WAYS - 1))
                victim_o = RANK_W'(w);
        end
    end

endmodule

// File: rtl/ctc_rank_next.sv
module ctc_rank_next #(
    parameter int WAYS   = 4,
    parameter int RANK_W = 2
) (
    input  logic [WAYS*RANK_W-1:0] ranks_i,
    input  logic [RANK_W-1:0]      touch_i,
    output logic [WAYS*RANK_W-1:0] ranks_o
);

    logic [RANK_W-1:0] touched_rank;

    assign touched_rank = ranks_i[touch_i*RANK_W +: RANK_W];

    // The touched way becomes newest; ways younger than it age by one.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_age
            logic [RANK_W-1:0] cur;
            assign cur = ranks_i[w*RANK_W +: RANK_W];
            assign ranks_o[w*RANK_W +: RANK_W] =
                (RANK_W'(w) == touch_i) ? '0 :
                (cur < touched_rank)    ? cur + RANK_W'(1) : cur;
        end
    endgenerate

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CACHE_BYTES = 256,
    parameter int BLOCK_BYTES = 16,
    parameter int UNIT_BYTES  = 1,
    parameter int WAYS        = 4,
    localparam int LINES  = CACHE_BYTES / BLOCK_BYTES,
    localparam int SETS   = LINES / WAYS,
    localparam int OFF_W  = $clog2(BLOCK_BYTES / UNIT_BYTES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W  = way_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              policy_lru,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_dirty,
    output logic              rsp_replace,
    output logic              rsp_writeback
);

    localparam int RANK_W = WAY_W;

    // Per-set storage
    logic [WAYS*TAG_W-1:0]  tag_mem  [SETS];
    logic [WAYS-1:0]        vld_mem  [SETS];
    logic [WAYS-1:0]        drt_mem  [SETS];
    logic [WAYS*RANK_W-1:0] rank_mem [SETS];

    ctl_state_e       state_q, state_d;
    logic [IDX_W-1:0] sweep_q;

    // Address fields
    logic [IDX_W-1:0] acc_idx;
    logic [TAG_W-1:0] acc_tag;
    logic             unused_offset;

    assign acc_idx       = req_addr[OFF_W +: IDX_W];
    assign acc_tag       = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    // Lookup of the addressed set
    logic [WAYS*TAG_W-1:0]  cur_tags;
    logic [WAYS-1:0]        cur_vld, cur_drt;
    logic [WAYS*RANK_W-1:0] cur_ranks, upd_ranks, init_ranks;
    logic                   hit, any_free;
    logic [WAY_W-1:0]       hit_way, free_way, vic_way, sel_way;

    assign cur_tags  = tag_mem[acc_idx];
    assign cur_vld   = vld_mem[acc_idx];
    assign cur_drt   = drt_mem[acc_idx];
    assign cur_ranks = rank_mem[acc_idx];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_init_rank
            assign init_ranks[w*RANK_W +: RANK_W] = RANK_W'(WAYS - 1 - w);
        end
    endgenerate

    ctc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .tags_i     (cur_tags),
        .valid_i    (cur_vld),
        .tag_i      (acc_tag),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .free_o     (any_free),
        .free_way_o (free_way)
    );

    ctc_victim_pick #(.WAYS(WAYS), .RANK_W(RANK_W)) u_victim (
        .ranks_i  (cur_ranks),
        .victim_o (vic_way)
    );

    ctc_rank_next #(.WAYS(WAYS), .RANK_W(RANK_W)) u_rank (
        .ranks_i (cur_ranks),
        .touch_i (sel_way),
        .ranks_o (upd_ranks)
    );

    // Control outputs derived from state and lookup
    logic accept, evict, evict_dirty, new_dirty, touch;

    always_comb begin
        req_ready   = (state_q == ST_SERVE);
        accept      = req_valid && req_ready;
        sel_way     = hit ? hit_way : (any_free ? free_way : vic_way);
        evict       = !hit && !any_free;
        evict_dirty = evict && cur_drt[vic_way];
        new_dirty   = req_write || (hit && cur_drt[hit_way]);
        touch       = hit ? policy_lru : 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) sweep_q <= sweep_q + IDX_W'(1);
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:  state_d = (sweep_q == IDX_W'(SETS - 1)) ? ST_SERVE : ST_INIT;
            ST_SERVE: state_d = ST_SERVE;
            default:  state_d = ST_INIT;
        endcase
    end

    // Storage update
    always_ff @(posedge clk) begin
        if (state_q == ST_INIT) begin
            vld_mem[sweep_q]  <= '0;
            drt_mem[sweep_q]  <= '0;
            rank_mem[sweep_q] <= init_ranks;
        end else if (accept) begin
            tag_mem[acc_idx][sel_way*TAG_W +: TAG_W] <= acc_tag;
            vld_mem[acc_idx][sel_way]                <= 1'b1;
            drt_mem[acc_idx][sel_way]                <= new_dirty;
            if (touch) rank_mem[acc_idx] <= upd_ranks;
        end
    end

    // Status record
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_index     <= '0;
            rsp_tag       <= '0;
            rsp_hit       <= 1'b0;
            rsp_way       <= '0;
            rsp_dirty     <= 1'b0;
            rsp_replace   <= 1'b0;
            rsp_writeback <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_index     <= acc_idx;
                rsp_tag       <= acc_tag;
                rsp_hit       <= hit;
                rsp_way       <= sel_way;
                rsp_dirty     <= new_dirty;
                rsp_replace   <= evict;
                rsp_writeback <= evict_dirty;
            end
        end
    end

    // Checks next to the logic they guard
    assert_rsp_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_rsp_without_accept_R3: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    assert_write_sets_dirty_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> rsp_dirty);

    assert_replace_only_on_miss_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_replace) |-> !rsp_hit);

    assert_wb_needs_replace_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_writeback) |-> rsp_replace);

    assert_fill_way_was_free_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !hit && any_free) |-> !cur_vld[free_way]);

endmodule

// File: tb/cache_tag_ctrl_tb.sv
module cache_tag_ctrl_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        policy_lru = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;

    // 4-way instance: 4 sets, tag 10 bits
    logic       a_ready, a_valid, a_hit, a_dirty, a_rep, a_wb;
    logic [1:0] a_idx, a_way;
    logic [9:0] a_tag;
    // direct-mapped instance: 16 sets, tag 8 bits
    logic       b_ready, b_valid, b_hit, b_dirty, b_rep, b_wb;
    logic [3:0] b_idx;
    logic [0:0] b_way;
    logic [7:0] b_tag;

    always #(CLK_P/2) clk = ~clk;

    cache_tag_ctrl #(.WAYS(4)) dut_i (
        .clk(clk), .rst(rst), .policy_lru(policy_lru),
        .req_valid(req_valid), .req_ready(a_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(a_valid), .rsp_index(a_idx), .rsp_tag(a_tag), .rsp_hit(a_hit),
        .rsp_way(a_way), .rsp_dirty(a_dirty), .rsp_replace(a_rep), .rsp_writeback(a_wb)
    );

    cache_tag_ctrl #(.WAYS(1)) dm_i (
        .clk(clk), .rst(rst), .policy_lru(policy_lru),
        .req_valid(req_valid), .req_ready(b_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(b_valid), .rsp_index(b_idx), .rsp_tag(b_tag), .rsp_hit(b_hit),
        .rsp_way(b_way), .rsp_dirty(b_dirty), .rsp_replace(b_rep), .rsp_writeback(b_wb)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Behavioural reference: per set, tag/valid/dirty per way and a queue of
    // way numbers from oldest (front) to newest (back).
    int mtag [2][16][4];
    bit mv   [2][16][4];
    bit md   [2][16][4];
    int ord_q [32][$];
    int e_idx[2], e_tag[2], e_hit[2], e_way[2], e_dirty[2], e_rep[2], e_wb[2];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < 2; i++)
            for (int s = 0; s < 16; s++) begin
                for (int k = 0; k < 4; k++) begin
                    mv[i][s][k] = 1'b0;
                    md[i][s][k] = 1'b0;
                end
                ord_q[i*16+s].delete();
            end
    endtask

    task automatic mdl(input int i, input int addr, input bit wr, input bit lru);
        int sets, ways, idxw, idx, tg, base, w, pos;
        sets = (i == 1) ? 16 : 4;
        ways = (i == 1) ? 1 : 4;
        idxw = (i == 1) ? 4 : 2;
        idx  = (addr >> 4) % sets;
        tg   = addr >> (4 + idxw);
        base = i*16 + idx;
        w    = -1;
        e_idx[i] = idx; e_tag[i] = tg; e_rep[i] = 0; e_wb[i] = 0;
        for (int k = 0; k < ways; k++)
            if (mv[i][idx][k] && mtag[i][idx][k] == tg) w = k;
        if (w >= 0) begin
            e_hit[i] = 1;
            if (lru) begin
                pos = -1;
                for (int p = 0; p < ord_q[base].size(); p++)
                    if (ord_q[base][p] == w) pos = p;
                ord_q[base].delete(pos);
                ord_q[base].push_back(w);
            end
            md[i][idx][w] = md[i][idx][w] | wr;
        end else begin
            e_hit[i] = 0;
            for (int k = ways - 1; k >= 0; k--)
                if (!mv[i][idx][k]) w = k;
            if (w < 0) begin
                w = ord_q[base].pop_front();
                e_rep[i] = 1;
                e_wb[i]  = md[i][idx][w];
            end
            ord_q[base].push_back(w);
            mtag[i][idx][w] = tg;
            mv[i][idx][w]   = 1'b1;
            md[i][idx][w]   = wr;
        end
        e_way[i]   = w;
        e_dirty[i] = md[i][idx][w];
    endtask

    function automatic string way_req(input int i);
        if (e_hit[i] != 0) return "R4";
        if (e_rep[i] == 0) return "R5";
        if (i == 1)        return "R11";
        return policy_lru ? "R6" : "R7";
    endfunction

    task automatic compare();
        chk("R3", "a_valid", a_valid, 1);
        chk("R1", "a_index", a_idx, e_idx[0]);
        chk("R1", "a_tag", a_tag, e_tag[0]);
        chk("R4", "a_hit", a_hit, e_hit[0]);
        chk(way_req(0), "a_way", a_way, e_way[0]);
        chk("R8", "a_dirty", a_dirty, e_dirty[0]);
        chk("R9", "a_replace", a_rep, e_rep[0]);
        chk("R10", "a_writeback", a_wb, e_wb[0]);
        chk("R3", "b_valid", b_valid, 1);
        chk("R1", "b_index", b_idx, e_idx[1]);
        chk("R1", "b_tag", b_tag, e_tag[1]);
        chk("R4", "b_hit", b_hit, e_hit[1]);
        chk(way_req(1), "b_way", b_way, e_way[1]);
        chk("R8", "b_dirty", b_dirty, e_dirty[1]);
        chk("R11", "b_replace", b_rep, e_rep[1]);
        chk("R10", "b_writeback", b_wb, e_wb[1]);
    endtask

    // Called at a negedge; returns at the negedge where the record is visible.
    task automatic access(input int addr, input bit wr);
        req_valid = 1'b1;
        req_addr  = 16'(addr);
        req_write = wr;
        @(posedge clk);
        mdl(0, addr, wr, policy_lru);
        mdl(1, addr, wr, policy_lru);
        @(negedge clk);
        req_valid = 1'b0;
        compare();
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "a_valid idle", a_valid, 0);
        chk("R3", "b_valid idle", b_valid, 0);
    endtask

    task automatic do_reset(input bit lru);
        int a_n, b_n;
        a_n = 0; b_n = 0;
        req_valid  = 1'b0;
        policy_lru = lru;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "a_valid in reset", a_valid, 0);
        chk("R2", "b_valid in reset", b_valid, 0);
        rst = 1'b0;
        mdl_clear();
        for (int n = 1; n <= 40; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R3", "a_valid during sweep", a_valid, 0);
            if (a_ready && a_n == 0) a_n = n;
            if (b_ready && b_n == 0) b_n = n;
        end
        chk("R2", "4-way sweep cycles", a_n, 4);
        chk("R2", "direct sweep cycles", b_n, 16);
    endtask

    task automatic directed();
        // Fill set 0 of the 4-way copy, then reorder by hits and evict.
        for (int t = 0; t < 4; t++) access(t << 6, 1'b0);
        access(0 << 6, 1'b0);
        access((1 << 6) | 3, 1'b1);
        idle();
        access(4 << 6, 1'b0);
        access(5 << 6, 1'b1);
        access(6 << 6, 1'b0);
        access(7 << 6, 1'b0);
        access(8 << 6, 1'b0);
        access(5 << 6, 1'b0);
        // Same block, different offsets: must hit.
        access((8 << 6) | 15, 1'b0);
    endtask

    task automatic stream(input int unsigned seed, input int count);
        int unsigned r;
        r = seed;
        for (int n = 0; n < count; n++) begin
            r = r * 1103515245 + 12345;
            access(int'((((r >> 8) % 6) << 8) | (((r >> 12) % 4) << 4) | ((r >> 16) % 16)),
                   r[20]);
            if (r[27:25] == 3'd0) idle();
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        directed();
        stream(32'h1234_5678, 300);
        do_reset(1'b0);
        directed();
        stream(32'h0bad_cafe, 300);
        idle();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule